// File: doc/BRIEF.md
# Branch Target and Condition Unit

This unit works out where a 16-bit-address CPU goes next after a branch. The decoder gives it the branch kind and the operands: the current program counter, an 8-bit signed displacement, a 16-bit absolute operand, and the A and X registers. It also gets the carry and zero flags. From these the unit decides whether the branch is taken. It forms the next program counter and reports how many instruction cycles the branch costs.

The result is captured in output registers on a load strobe. It holds there until the next strobe, so the rest of the pipeline can read it at leisure. Relative targets are measured from the address that follows the two-byte branch. The register-indirect jump builds its target from two separate 8-bit registers. All target arithmetic wraps modulo 2^16. The unit never changes any flag; it only reads carry and zero.

Top module: `brtgt_unit`

## Requirements
- R1: After reset, the outputs read as follows: taken_o = 0, npc_o = 0000h, cyc_o = 0. They stay there until the first load strobe is accepted.
- R2: Kind 0 (absolute jump) gives taken_o = 1, npc_o = abs_i and cyc_o = 6. The displacement and both flags have no effect.
- R3: Kind 1 (relative jump) gives taken_o = 1 and cyc_o = 6. npc_o is pc_i + 2 plus disp_i, with disp_i read as a two's-complement byte.
- R4: Kind 2 (register-indirect jump) gives taken_o = 1 and cyc_o = 8. npc_o has a_i in bits 15:8 and x_i in bits 7:0.
- R5: Kinds 3, 4, 5 and 6 are conditional branches. They are taken when, in that order, CY = 1, CY = 0, Z = 1 and Z = 0 (cy_i and z_i). When taken, npc_o is the relative target of R3, taken_o = 1 and cyc_o = 6.
- R6: A conditional branch whose condition fails gives taken_o = 0, npc_o = pc_i + 2 and cyc_o = 6.
- R7: Target sums wrap modulo 65536. Displacements 80h to FFh move the target backward by 256 minus the value.
- R8: Each output changes only on a rising clock edge at which ld_i = 1. In that case it shows the result for the inputs present at that edge; otherwise all outputs hold.
- R9: Kind 7 is reserved. It gives taken_o = 0, npc_o = pc_i + 2 and cyc_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released on the clock |
| ld_i | input | 1 | Load strobe that captures a new result |
| kind_i | input | 3 | Branch kind code (0 to 7, see R2 to R9) |
| pc_i | input | 16 | Address of the branch instruction |
| disp_i | input | 8 | Signed relative displacement |
| abs_i | input | 16 | Absolute target operand |
| a_i | input | 8 | A register, high byte of the indirect target |
| x_i | input | 8 | X register, low byte of the indirect target |
| cy_i | input | 1 | Carry flag |
| z_i | input | 1 | Zero flag |
| taken_o | output | 1 | Branch taken |
| npc_o | output | 16 | Next program counter |
| cyc_o | output | 4 | Instruction cycle count |

## Verification
The bench builds the unit with its default widths: a 16-bit address, an 8-bit displacement and 8-bit A and X registers. It uses the default cycle counts of 6 and 8. With these widths, a program counter near FFFFh or 0000h, combined with the displacement extremes 7Fh and 80h, reaches the wrap in both directions. The full byte range of the indirect registers is also reachable. Random runs cover every kind with both flag values and with strobe gaps, so the hold behaviour is exercised between loads.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;
  typedef enum logic [2:0] {
    BK_ABS  = 3'd0,
    BK_REL  = 3'd1,
    BK_REG  = 3'd2,
    BK_CSET = 3'd3,
    BK_CCLR = 3'd4,
    BK_ZSET = 3'd5,
    BK_ZCLR = 3'd6,
    BK_RSV  = 3'd7
  } bkind_e;
endpackage

// File: rtl/brtgt_rstsync.sv
module brtgt_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sn = s2_q;
endmodule

// File: rtl/brtgt_cond.sv
module brtgt_cond
  import brtgt_pkg::*;
#(
  parameter int CW       = 4,
  parameter int CYC_DIR  = 6,
  parameter int CYC_IND  = 8,
  parameter int CYC_COND = 6
) (
  input  bkind_e        kind,
  input  logic          cy,
  input  logic          z,
  output logic          taken,
  output logic          is_cond,
  output logic [CW-1:0] cyc
);
  always_comb begin
    taken   = 1'b0;
    is_cond = 1'b0;
    cyc     = '0;
    unique case (kind)
      BK_ABS, BK_REL: begin
        taken = 1'b1;
        cyc   = CW'(CYC_DIR);
      end
      BK_REG: begin
        taken = 1'b1;
        cyc   = CW'(CYC_IND);
      end
      BK_CSET: begin
        is_cond = 1'b1;
        taken   = cy;
        cyc     = CW'(CYC_COND);
      end
      BK_CCLR: begin
        is_cond = 1'b1;
        taken   = ~cy;
        cyc     = CW'(CYC_COND);
      end
      BK_ZSET: begin
        is_cond = 1'b1;
        taken   = z;
        cyc     = CW'(CYC_COND);
      end
      BK_ZCLR: begin
        is_cond = 1'b1;
        taken   = ~z;
        cyc     = CW'(CYC_COND);
      end
      default: begin
        taken = 1'b0;
        cyc   = '0;
      end
    endcase
  end
endmodule

// File: rtl/brtgt_addr.sv
module brtgt_addr
  import brtgt_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int RW   = 8,
  parameter int ILEN = 2
) (
  input  bkind_e          kind,
  input  logic            taken,
  input  logic [AW-1:0]   pc,
  input  logic [DW-1:0]   disp,
  input  logic [AW-1:0]   abs_t,
  input  logic [RW-1:0]   ra,
  input  logic [RW-1:0]   rx,
  output logic [AW-1:0]   npc
);
  localparam int XW = AW - DW;

  logic [AW-1:0] seq_pc;
  logic [AW-1:0] sdisp;
  logic [AW-1:0] rel_pc;
  logic [AW-1:0] ind_pc;

  assign seq_pc = pc + AW'(ILEN);

  generate
    if (XW > 0) begin : g_sext
      assign sdisp = {{XW{disp[DW-1]}}, disp};
    end else begin : g_trunc
      assign sdisp = disp[AW-1:0];
    end
  endgenerate

  assign rel_pc = seq_pc + sdisp;

  generate
    if (2 * RW >= AW) begin : g_ind_fit
      localparam logic [2*RW-1:0] ZPAD = '0;
      logic [2*RW-1:0] pair;
      assign pair   = {ra, rx} | ZPAD;
      assign ind_pc = pair[AW-1:0];
    end else begin : g_ind_pad
      assign ind_pc = {{(AW-2*RW){1'b0}}, ra, rx};
    end
  endgenerate

  always_comb begin
    npc = seq_pc;
    if (taken) begin
      unique case (kind)
        BK_ABS:  npc = abs_t;
        BK_REG:  npc = ind_pc;
        default: npc = rel_pc;
      endcase
    end
  end
endmodule

// File: rtl/brtgt_reg.sv
module brtgt_reg #(
  parameter int AW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          ld,
  input  logic          taken_d,
  input  logic [AW-1:0] npc_d,
  input  logic [CW-1:0] cyc_d,
  output logic          taken_q,
  output logic [AW-1:0] npc_q,
  output logic [CW-1:0] cyc_q
);
  logic          taken_n;
  logic [AW-1:0] npc_n;
  logic [CW-1:0] cyc_n;

  always_comb begin
    taken_n = taken_q;
    npc_n   = npc_q;
    cyc_n   = cyc_q;
    if (ld) begin
      taken_n = taken_d;
      npc_n   = npc_d;
      cyc_n   = cyc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      taken_q <= 1'b0;
      npc_q   <= '0;
      cyc_q   <= '0;
    end else begin
      taken_q <= taken_n;
      npc_q   <= npc_n;
      cyc_q   <= cyc_n;
    end
  end

  // R8: no strobe, no change
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    !ld |=> ($stable(taken_q) && $stable(npc_q) && $stable(cyc_q)));
endmodule

// File: rtl/brtgt_unit.sv
module brtgt_unit
  import brtgt_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int RW       = 8,
  parameter int CW       = 4,
  parameter int ILEN     = 2,
  parameter int CYC_DIR  = 6,
  parameter int CYC_IND  = 8,
  parameter int CYC_COND = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic [2:0]    kind_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] disp_i,
  input  logic [AW-1:0] abs_i,
  input  logic [RW-1:0] a_i,
  input  logic [RW-1:0] x_i,
  input  logic          cy_i,
  input  logic          z_i,
  output logic          taken_o,
  output logic [AW-1:0] npc_o,
  output logic [CW-1:0] cyc_o
);
  bkind_e        kind;
  logic          rst_s;
  logic          taken_c;
  logic          cond_c;
  logic [CW-1:0] cyc_c;
  logic [AW-1:0] npc_c;

  assign kind = bkind_e'(kind_i);

  brtgt_rstsync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_s)
  );

  brtgt_cond #(
    .CW(CW), .CYC_DIR(CYC_DIR), .CYC_IND(CYC_IND), .CYC_COND(CYC_COND)
  ) u_cond (
    .kind    (kind),
    .cy      (cy_i),
    .z       (z_i),
    .taken   (taken_c),
    .is_cond (cond_c),
    .cyc     (cyc_c)
  );

  brtgt_addr #(.AW(AW), .DW(DW), .RW(RW), .ILEN(ILEN)) u_addr (
    .kind  (kind),
    .taken (taken_c),
    .pc    (pc_i),
    .disp  (disp_i),
    .abs_t (abs_i),
    .ra    (a_i),
    .rx    (x_i),
    .npc   (npc_c)
  );

  brtgt_reg #(.AW(AW), .CW(CW)) u_reg (
    .clk     (clk),
    .rst_sn  (rst_s),
    .ld      (ld_i),
    .taken_d (taken_c),
    .npc_d   (npc_c),
    .cyc_d   (cyc_c),
    .taken_q (taken_o),
    .npc_q   (npc_o),
    .cyc_q   (cyc_o)
  );

  // R2: absolute jump loads the operand
  p_abs_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (ld_i && kind_i == 3'd0) |=>
      (taken_o && npc_o == $past(abs_i) && cyc_o == CW'(CYC_DIR)));

  // R4: indirect target from the two registers
  p_ind_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (ld_i && kind_i == 3'd2) |=>
      (taken_o && npc_o[RW-1:0] == $past(x_i) && cyc_o == CW'(CYC_IND)));

  // R6: failed condition falls through
  p_fall_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (ld_i && cond_c && !taken_c) |=>
      (!taken_o && npc_o == $past(pc_i) + AW'(ILEN) && cyc_o == CW'(CYC_COND)));

  // R5: a passed condition is reported as taken
  p_cond_taken_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (ld_i && cond_c && taken_c) |=> (taken_o && cyc_o == CW'(CYC_COND)));

  // R9: reserved kind never branches
  p_rsv_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (ld_i && kind_i == 3'd7) |=>
      (!taken_o && cyc_o == '0 && npc_o == $past(pc_i) + AW'(ILEN)));
endmodule

// File: tb/sim_brtgt_unit.sv
`timescale 1ns/1ps
module sim_brtgt_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_i = 1'b0;
  logic [2:0]  kind_i = 3'd0;
  logic [15:0] pc_i = '0;
  logic [7:0]  disp_i = '0;
  logic [15:0] abs_i = '0;
  logic [7:0]  a_i = '0;
  logic [7:0]  x_i = '0;
  logic        cy_i = 1'b0;
  logic        z_i = 1'b0;
  logic        taken_o;
  logic [15:0] npc_o;
  logic [3:0]  cyc_o;

  int total = 0;
  int bad = 0;
  bit run = 1'b0;
  bit done = 1'b0;
  string tag = "R1";

  int exp_t = 0;
  int exp_pc = 0;
  int exp_c = 0;

  always #10 clk = ~clk;

  brtgt_unit u0 (
    .clk(clk), .rst_n(rst_n), .ld_i(ld_i), .kind_i(kind_i), .pc_i(pc_i),
    .disp_i(disp_i), .abs_i(abs_i), .a_i(a_i), .x_i(x_i), .cy_i(cy_i),
    .z_i(z_i), .taken_o(taken_o), .npc_o(npc_o), .cyc_o(cyc_o)
  );

  // Behavioural reference, updated on each accepted strobe
  always @(posedge clk) begin
    if (run && ld_i) begin
      int sd;
      int k;
      bit tk;
      k  = int'(kind_i);
      sd = (disp_i >= 8'h80) ? int'(disp_i) - 256 : int'(disp_i);
      tk = 1'b0;
      case (k)
        0, 1, 2: tk = 1'b1;
        3: tk = cy_i;
        4: tk = !cy_i;
        5: tk = z_i;
        6: tk = !z_i;
        default: tk = 1'b0;
      endcase
      exp_t  = tk ? 1 : 0;
      exp_c  = (k == 7) ? 0 : ((k == 2) ? 8 : 6);
      if (!tk)         exp_pc = (int'(pc_i) + 2) & 16'hFFFF;
      else if (k == 0) exp_pc = int'(abs_i);
      else if (k == 2) exp_pc = int'(a_i) * 256 + int'(x_i);
      else             exp_pc = (int'(pc_i) + 2 + sd) & 16'hFFFF;
    end
  end

  always @(negedge clk) begin
    if (run && !done) begin
      total++;
      if (int'(taken_o) != exp_t || int'(npc_o) != exp_pc || int'(cyc_o) != exp_c) begin
        bad++;
        $display("FAIL %s: actual taken=%0d npc=%04h cyc=%0d expected taken=%0d npc=%04h cyc=%0d",
                 tag, taken_o, npc_o, cyc_o, exp_t, exp_pc[15:0], exp_c);
      end
    end
  end

  task automatic drive(input string t, input logic ld, input logic [2:0] k,
                       input logic [15:0] pc, input logic [7:0] d,
                       input logic [15:0] ab, input logic [7:0] a,
                       input logic [7:0] x, input logic c, input logic zz);
    @(negedge clk);
    #2;
    tag = t; ld_i = ld; kind_i = k; pc_i = pc; disp_i = d; abs_i = ab;
    a_i = a; x_i = x; cy_i = c; z_i = zz;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    run = 1'b1;
    // R1: reset values held with no strobe
    repeat (3) drive("R1", 1'b0, 3'd0, 16'h1234, 8'h10, 16'hBEEF, 8'h12, 8'h34, 1'b1, 1'b1);
    // R2: absolute, operands and flags ignored
    drive("R2", 1'b1, 3'd0, 16'h1000, 8'h80, 16'hBEEF, 8'h00, 8'h00, 1'b0, 1'b0);
    drive("R2", 1'b1, 3'd0, 16'hFFFF, 8'h7F, 16'h0000, 8'hFF, 8'hFF, 1'b1, 1'b1);
    // R3: relative forward and backward
    drive("R3", 1'b1, 3'd1, 16'h2000, 8'h10, 16'h5555, 8'h00, 8'h00, 1'b0, 1'b0);
    drive("R3", 1'b1, 3'd1, 16'h2000, 8'hFE, 16'h5555, 8'h00, 8'h00, 1'b1, 1'b1);
    // R7: wrap both ways and displacement extremes
    drive("R7", 1'b1, 3'd1, 16'hFFF0, 8'h7F, 16'h0, 8'h0, 8'h0, 1'b0, 1'b0);
    drive("R7", 1'b1, 3'd1, 16'h0010, 8'h80, 16'h0, 8'h0, 8'h0, 1'b0, 1'b0);
    drive("R7", 1'b1, 3'd3, 16'hFFFE, 8'h00, 16'h0, 8'h0, 8'h0, 1'b0, 1'b0);
    // R4: indirect
    drive("R4", 1'b1, 3'd2, 16'h3000, 8'h44, 16'h9999, 8'hA5, 8'h3C, 1'b0, 1'b1);
    drive("R4", 1'b1, 3'd2, 16'h3000, 8'h44, 16'h9999, 8'h00, 8'hFF, 1'b1, 1'b0);
    // R5: each condition taken
    drive("R5", 1'b1, 3'd3, 16'h4000, 8'h20, 16'h0, 8'h0, 8'h0, 1'b1, 1'b0);
    drive("R5", 1'b1, 3'd4, 16'h4000, 8'hE0, 16'h0, 8'h0, 8'h0, 1'b0, 1'b1);
    drive("R5", 1'b1, 3'd5, 16'h4000, 8'h05, 16'h0, 8'h0, 8'h0, 1'b0, 1'b1);
    drive("R5", 1'b1, 3'd6, 16'h4000, 8'h81, 16'h0, 8'h0, 8'h0, 1'b1, 1'b0);
    // R6: each condition failing
    drive("R6", 1'b1, 3'd3, 16'h5000, 8'h20, 16'h0, 8'h0, 8'h0, 1'b0, 1'b1);
    drive("R6", 1'b1, 3'd4, 16'h5000, 8'h20, 16'h0, 8'h0, 8'h0, 1'b1, 1'b0);
    drive("R6", 1'b1, 3'd5, 16'h5000, 8'h20, 16'h0, 8'h0, 8'h0, 1'b1, 1'b0);
    drive("R6", 1'b1, 3'd6, 16'hFFFF, 8'h20, 16'h0, 8'h0, 8'h0, 1'b0, 1'b1);
    // R9: reserved
    drive("R9", 1'b1, 3'd7, 16'h6000, 8'h7F, 16'h1111, 8'h22, 8'h33, 1'b1, 1'b1);
    // R8: no strobe with changing inputs
    drive("R8", 1'b0, 3'd0, 16'h7000, 8'h00, 16'hAAAA, 8'h0, 8'h0, 1'b0, 1'b0);
    drive("R8", 1'b0, 3'd2, 16'h7000, 8'h00, 16'hAAAA, 8'h55, 8'h66, 1'b0, 1'b0);
    drive("R8", 1'b0, 3'd1, 16'h7000, 8'h40, 16'hAAAA, 8'h0, 8'h0, 1'b1, 1'b1);
    // R5: random mix with strobe gaps
    for (int i = 0; i < 400; i++) begin
      logic [2:0] k;
      k = 3'($urandom_range(0, 7));
      drive((k >= 3'd3 && k <= 3'd6) ? "R5" : "R8", 1'($urandom_range(0, 3) != 0), k,
            16'($urandom), 8'($urandom), 16'($urandom), 8'($urandom), 8'($urandom),
            1'($urandom), 1'($urandom));
    end
    drive("R8", 1'b0, 3'd0, 16'h0, 8'h0, 16'h0, 8'h0, 8'h0, 1'b0, 1'b0);
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule